// File: doc/BRIEF.md
# Crosspoint Parallel Command Controller

This block is the digital control core of an 8x8 crosspoint switch, used in its parallel programming mode. A host presents a 3-bit output address and a 4-bit nibble, then raises a write strobe. The nibble is either a routing code, which is staged for the addressed output, or a command, which acts at once on output enables or on the routing transfer. The strobe counts only while both chip enables are asserted.

Routing codes are staged in one master register per output. They reach the slave registers, which drive the switch matrix, only under control of a latch input. A strap selects how the latch input acts. In edge mode, a rising edge of the latch copies all masters to the slaves. In level mode, the slaves follow the masters for as long as the latch is low.

Enable and disable commands bypass the latch and act on the write edge. The strobe and the latch are asynchronous to the system clock, so each passes through a two-flop synchronizer before its edge is detected.

Top module: `xpt_par_ctrl`

## Requirements
- R1: A write strobe rising edge is acted upon only while `wr_ce_n_i` is 0 and `wr_ce_i` is 1. With any other combination the write changes neither the staging, the routing nor the enables.
- R2: Nibble values 0 to 8 load into the master register of the output chosen by `addr_i`. For a slave value v from 0 to 7, `sel_o[3*k+:3]` = v and `gnd_o[k]` = 0. For v = 8, `gnd_o[k]` = 1 and `sel_o[3*k+:3]` = 0.
- R3: Nibble values 11 to 15 are commands and are never stored in any master register.
- R4: Nibble values 9 and 10 have no effect on masters, slaves or enables.
- R5: Command 14 sets every enable and 13 clears every enable. Command 12 sets only the addressed enable and 11 clears only the addressed enable. These commands act whatever the latch state or mode.
- R6: Command 15 copies all masters to the slaves when the synchronized latch is high. It is a no-operation when the latch is low.
- R7: With `edge_mode_i` = 1, the slaves take the masters on a latch rising edge only. A steady latch or a falling latch leaves the slaves unchanged.
- R8: With `edge_mode_i` = 0, the slaves follow the masters while the latch is 0 and hold while it is 1.
- R9: After reset every enable is 0 and every master and slave holds 0, so every output selects input 0.
- R10: Disabling and then re-enabling outputs keeps the routing held in the slaves.
- R11: The effect of a write is visible at the outputs by the fourth rising clock edge after `wr_i` rises. The effect of a latch change is visible by the fourth edge after `latch_i` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe, asynchronous, acts on rising edge |
| wr_ce_n_i | input | 1 | Active-low write enable |
| wr_ce_i | input | 1 | Active-high write enable |
| addr_i | input | 3 | Output address for the write |
| nib_i | input | 4 | Routing code or command |
| latch_i | input | 1 | Transfer control, asynchronous |
| edge_mode_i | input | 1 | 1 = transfer on latch rising edge, 0 = transfer while latch low |
| sel_o | output | 24 | Selected input per output, 3 bits each, output k at bits 3k+2..3k |
| gnd_o | output | 8 | Output k routed to ground |
| en_o | output | 8 | Output k enabled |

## Verification
The embedded properties check the following on every cycle:
- Slaves move only on a transfer event, and each transfer copies the master contents exactly.
- Masters change only on a routing load.
- Command writes never touch a master.
- Enables move only on an accepted enable or disable command.

Only the bench scenarios can show the end-to-end ordering behaviour: staging under a high latch, the software latch being ignored while the latch is low, the edge-mode rise against a steady or falling latch, and routing surviving a disable and enable cycle. The bench also runs an exhaustive sweep of every address against every nibble value.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int CODE_W   = 4;
  localparam int CODE_GND = 8;
  localparam int CMD_DIS1 = 11;
  localparam int CMD_EN1  = 12;
  localparam int CMD_DISA = 13;
  localparam int CMD_ENA  = 14;
  localparam int CMD_SWL  = 15;

  function automatic logic is_route(input logic [CODE_W-1:0] c);
    return c <= CODE_W'(CODE_GND);
  endfunction

  function automatic logic is_gnd(input logic [CODE_W-1:0] c);
    return c == CODE_W'(CODE_GND);
  endfunction

  function automatic logic [CODE_W-2:0] to_sel(input logic [CODE_W-1:0] c);
    return c[CODE_W-1] ? '0 : c[CODE_W-2:0];
  endfunction
endpackage

// File: rtl/xpt_sync_edge.sv
module xpt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/xpt_master_bank.sv
module xpt_master_bank
  import xpt_pkg::*;
#(
  parameter int N_OUT  = 8,
  parameter int ADDR_W = $clog2(N_OUT)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [CODE_W-1:0]             code_i,
  output logic [N_OUT-1:0][CODE_W-1:0]  mst_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mst_o <= '0;
    else if (load_i) mst_o[addr_i] <= code_i;
  end

  // R2: staging only changes on a routing load
  p_master_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(mst_o));
endmodule

// File: rtl/xpt_slave_bank.sv
module xpt_slave_bank
  import xpt_pkg::*;
#(
  parameter int N_OUT = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          xfer_i,
  input  logic [N_OUT-1:0][CODE_W-1:0]  mst_i,
  output logic [N_OUT-1:0][CODE_W-1:0]  slv_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      slv_o <= '0;
    else if (xfer_i) slv_o <= mst_i;
  end

  // R7: routing is held between transfers
  p_slave_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_i |=> $stable(slv_o));
  // R8: a transfer copies the staged codes exactly
  p_slave_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_i |=> (slv_o == $past(mst_i)));
endmodule

// File: rtl/xpt_par_ctrl.sv
module xpt_par_ctrl
  import xpt_pkg::*;
#(
  parameter int N_OUT  = 8,
  parameter int STAGES = 2,
  localparam int ADDR_W = $clog2(N_OUT),
  localparam int SEL_W  = CODE_W - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_i,
  input  logic                    wr_ce_n_i,
  input  logic                    wr_ce_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [CODE_W-1:0]       nib_i,
  input  logic                    latch_i,
  input  logic                    edge_mode_i,
  output logic [N_OUT*SEL_W-1:0]  sel_o,
  output logic [N_OUT-1:0]        gnd_o,
  output logic [N_OUT-1:0]        en_o
);
  logic wr_lvl, wr_rise, lat_lvl, lat_rise;
  logic wr_ev, load, sw_latch, xfer;
  logic [N_OUT-1:0][CODE_W-1:0] mst_q, slv_q;
  logic [N_OUT-1:0] en_q;

  xpt_sync_edge #(.STAGES(STAGES)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .d_i(wr_i), .lvl_o(wr_lvl), .rise_o(wr_rise));
  xpt_sync_edge #(.STAGES(STAGES)) u_lat_sync (
    .clk(clk), .rst_n(rst_n), .d_i(latch_i), .lvl_o(lat_lvl), .rise_o(lat_rise));

  // Decoded write events
  assign wr_ev    = wr_rise & ~wr_ce_n_i & wr_ce_i;
  assign load     = wr_ev & is_route(nib_i);
  assign sw_latch = wr_ev & (nib_i == CODE_W'(CMD_SWL)) & lat_lvl;
  assign xfer     = edge_mode_i ? (lat_rise | sw_latch) : (~lat_lvl | sw_latch);

  xpt_master_bank #(.N_OUT(N_OUT)) u_master (
    .clk(clk), .rst_n(rst_n), .load_i(load), .addr_i(addr_i),
    .code_i(nib_i), .mst_o(mst_q));

  xpt_slave_bank #(.N_OUT(N_OUT)) u_slave (
    .clk(clk), .rst_n(rst_n), .xfer_i(xfer), .mst_i(mst_q), .slv_o(slv_q));

  // Enable flags: commands act on the write edge regardless of latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr_ev) begin
      case (nib_i)
        CODE_W'(CMD_DIS1): en_q[addr_i] <= 1'b0;
        CODE_W'(CMD_EN1):  en_q[addr_i] <= 1'b1;
        CODE_W'(CMD_DISA): en_q <= '0;
        CODE_W'(CMD_ENA):  en_q <= '1;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assign sel_o[k*SEL_W +: SEL_W] = to_sel(slv_q[k]);
    assign gnd_o[k]                = is_gnd(slv_q[k]);
  end
  assign en_o = en_q;

  // R3: command nibbles never reach the staging registers
  p_cmd_not_stored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && nib_i > CODE_W'(CODE_GND)) |=> $stable(mst_q));
  // R5: enables move only on an accepted enable/disable command
  p_en_only_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ev && nib_i >= CODE_W'(CMD_DIS1) && nib_i <= CODE_W'(CMD_ENA))
      |=> $stable(en_q));
  // R1: no strobe is accepted while chip enables are inactive
  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ce_n_i || !wr_ce_i) |=> ($stable(en_q) && $stable(mst_q)));
endmodule

// File: tb/test_xpt_par_ctrl.sv
module test_xpt_par_ctrl;
  logic clk = 0, rst_n = 0;
  logic wr_i = 0, wr_ce_n_i = 0, wr_ce_i = 1;
  logic [2:0] addr_i = 0;
  logic [3:0] nib_i = 0;
  logic latch_i = 1, edge_mode_i = 0;
  logic [23:0] sel_o;
  logic [7:0] gnd_o, en_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [3:0] m [8];
  logic [3:0] s [8];
  bit en [8];

  always #2 clk = ~clk;

  xpt_par_ctrl i_xpt_par_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .wr_ce_n_i(wr_ce_n_i),
    .wr_ce_i(wr_ce_i), .addr_i(addr_i), .nib_i(nib_i), .latch_i(latch_i),
    .edge_mode_i(edge_mode_i), .sel_o(sel_o), .gnd_o(gnd_o), .en_o(en_o));

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Level mode with low latch: slaves follow masters
  task automatic track();
    if (!edge_mode_i && !latch_i) for (int k = 0; k < 8; k++) s[k] = m[k];
  endtask

  task automatic check(string rq);
    logic [23:0] es; logic [7:0] eg, ee;
    for (int k = 0; k < 8; k++) begin
      es[k*3 +: 3] = (s[k] < 8) ? s[k][2:0] : 3'd0;
      eg[k] = (s[k] == 8);
      ee[k] = en[k];
    end
    n_chk++;
    if (sel_o !== es || gnd_o !== eg || en_o !== ee) begin
      n_fail++;
      $display("FAIL %s: sel=%h gnd=%b en=%b expected sel=%h gnd=%b en=%b",
               rq, sel_o, gnd_o, en_o, es, eg, ee);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] c,
                    input logic cen = 0, input logic ce = 1);
    addr_i = a; nib_i = c; wr_ce_n_i = cen; wr_ce_i = ce;
    tick(2);
    wr_i = 1;
    tick(4);  // R11: effects must be visible after four edges
    if (!cen && ce) begin
      if (c <= 8) m[a] = c;
      else if (c == 11) en[a] = 0;
      else if (c == 12) en[a] = 1;
      else if (c == 13) for (int k = 0; k < 8; k++) en[k] = 0;
      else if (c == 14) for (int k = 0; k < 8; k++) en[k] = 1;
      else if (c == 15 && latch_i) for (int k = 0; k < 8; k++) s[k] = m[k];
    end
    track();
    wr_i = 0;
    tick(3);
    wr_ce_n_i = 0; wr_ce_i = 1;
  endtask

  task automatic set_latch(input logic v);
    if (edge_mode_i && v && !latch_i) for (int k = 0; k < 8; k++) s[k] = m[k];
    latch_i = v;
    tick(4);
    track();
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin m[k] = 0; s[k] = 0; en[k] = 0; end
    tick(3); rst_n = 1; tick(4);
    check("R9 reset state");

    // Level mode, latch high: staging only
    wr(1, 1); wr(2, 1); wr(4, 2); wr(5, 2); wr(7, 8);
    check("R8 staged, not routed while latch high");
    wr(0, 14); check("R5 enable all ignores latch");
    set_latch(0); check("R8 latch low transfers");
    check("R2 ground code on output 7");
    wr(3, 13); check("R5 disable all");
    wr(3, 14); check("R10 routing kept after re-enable");
    wr(7, 3); check("R11 immediate route with latch low");
    set_latch(1); wr(5, 3); check("R8 hold while latch high");
    wr(0, 15); check("R6 software latch with latch high");

    // Edge mode
    edge_mode_i = 1; set_latch(0);
    wr(6, 3); wr(0, 15); check("R6 software latch NOP with latch low");
    set_latch(1); check("R7 rising latch transfers");
    wr(6, 5); tick(8); check("R7 steady latch holds");
    set_latch(0); check("R7 falling latch holds");
    set_latch(1); check("R7 second rise");

    // Chip enable gating
    wr(2, 13, 1, 1); check("R1 ce_n high blocks");
    wr(2, 13, 0, 0); check("R1 ce low blocks");
    wr(2, 6, 1, 0); set_latch(0); set_latch(1); check("R1 gated route not staged");

    // Codes 9/10 and commands never stored
    wr(4, 9); wr(4, 10); wr(4, 11); wr(4, 12); wr(4, 15);
    set_latch(0); set_latch(1); check("R4 R3 no staging by 9..15");

    // Exhaustive sweep in level mode, latch low
    edge_mode_i = 0; set_latch(0);
    for (int a = 0; a < 8; a++)
      for (int c = 0; c < 16; c++) begin
        wr(a[2:0], c[3:0]);
        if (c <= 8) check("R2 sweep route");
        else if (c <= 10) check("R4 sweep nop");
        else if (c <= 14) check("R5 sweep enable cmd");
        else check("R3 sweep swlatch");
      end
    for (int a = 0; a < 8; a++) begin
      wr(a[2:0], 11); check("R5 addressed disable");
      wr(a[2:0], 12); check("R10 addressed enable keeps route");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule